// File: doc/BRIEF.md
# Staged Error Aggregation Pipeline

This block gathers the fault conditions that a six-stage datapath raises for one transaction and reduces them to a single error bit at the last stage. A transaction enters at stage 1 with a valid bit. Its first two conditions (malformed operand and unsupported operation) are sampled in the same cycle. Its overflow condition is sampled two clocks later, at stage 3. Its divide-by-zero condition is sampled five clocks later, at stage 6.

Every partial flag is carried through staging registers next to the transaction's valid bit. Each partial flag is therefore combined only with conditions of the same transaction, and never with raw signals from neighbouring cycles. The datapath that raises the conditions lies outside this block.

There is no state machine. The block is a straight-line pipeline of two delay lines and three merge points, with fixed latency and one transaction accepted per clock.

Top module: `err_pipe_agg`

## Requirements
- R1: When a valid transaction has its malformed-operand or unsupported-operation input high in its stage-1 cycle n, err_o is 1 in cycle n+5.
- R2: When a valid transaction has overflow_i high in cycle n+2, which is its stage-3 slot, err_o is 1 in cycle n+5.
- R3: When div_zero_i is high in the cycle where txn_vld_o is 1, err_o is 1 in that same cycle; this input has no register before the output.
- R4: A valid transaction with none of its four conditions raised gives err_o = 0 while txn_vld_o = 1.
- R5: txn_vld_o in cycle n+5 equals txn_vld_i in cycle n, so the latency is five clocks and a new transaction can enter every clock.
- R6: err_o is never 1 while txn_vld_o is 0.
- R7: A condition raised in a slot whose transaction is not valid is ignored: err_o stays 0 for that slot.
- R8: A condition is credited only to the transaction that occupies its stage in that cycle. For example, overflow_i in cycle n+3 affects the transaction that entered in cycle n+1, and does not affect the one that entered in cycle n.
- R9: A synchronous reset clears every staging register. For the first five cycles after reset is released, txn_vld_o = 0 and err_o = 0, even if transactions were in flight when reset was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txn_vld_i | input | 1 | A transaction enters stage 1 this cycle |
| bad_input_i | input | 1 | Malformed operand, stage 1 |
| illegal_op_i | input | 1 | Unsupported operation, stage 1 |
| overflow_i | input | 1 | Arithmetic overflow, stage 3 |
| div_zero_i | input | 1 | Division by zero, stage 6 |
| txn_vld_o | output | 1 | Stage-6 slot holds a transaction |
| err_o | output | 1 | Combined error flag of the stage-6 transaction |

## Verification
The assertions take for granted that reset is high at time zero and on the first clock edge. They also assume that each condition input is meaningful only in the stage slot it belongs to, and that div_zero_i settles before the edge on which the output is sampled.

The stimulus keeps within these assumptions:
- It starts under reset.
- It changes inputs only on the falling edge.
- It raises conditions in invalid slots and in misaligned cycles on purpose, so that a flag taken from the wrong cycle shows up as a mismatch.

A second reset in the middle of a dense random stream tests the clearing of transactions that were in flight.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;

    typedef struct packed {
        logic vld;
        logic err;
    } tok_t;

    localparam tok_t TOK_IDLE = '{vld: 1'b0, err: 1'b0};

endpackage

// File: rtl/err_tok_delay.sv
module err_tok_delay
    import err_agg_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  tok_t d,
    output tok_t q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            tok_t stg [DEPTH];

            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stg[i] <= TOK_IDLE;
                    end else if (i == 0) begin
                        stg[i] <= d;
                    end else begin
                        stg[i] <= stg[(i == 0) ? 0 : i - 1];
                    end
                end
            end

            assign q = stg[DEPTH-1];

            // R6: a carried error flag always travels with a valid slot
            assert_carried_err_has_vld_R6: assert property (
                @(posedge clk) disable iff (rst)
                q.err |-> q.vld
            );
        end
    endgenerate

endmodule

// File: rtl/err_stage_merge.sv
module err_stage_merge
    import err_agg_pkg::*;
(
    input  tok_t up,
    input  logic cond,
    output tok_t dn
);

    always_comb begin
        dn.vld = up.vld;
        dn.err = up.vld & (up.err | cond);
    end

endmodule

// File: rtl/err_pipe_agg.sv
module err_pipe_agg
    import err_agg_pkg::*;
#(
    parameter int OVF_STAGE = 3,
    parameter int DIV_STAGE = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic txn_vld_i,
    input  logic bad_input_i,
    input  logic illegal_op_i,
    input  logic overflow_i,
    input  logic div_zero_i,
    output logic txn_vld_o,
    output logic err_o
);

    localparam int HOP_A  = OVF_STAGE - 1;
    localparam int HOP_B  = DIV_STAGE - OVF_STAGE;
    localparam int LAT    = DIV_STAGE - 1;
    localparam int FCW    = $clog2(LAT + 1) + 1;

    tok_t s1_entry;
    tok_t s1_tok;
    tok_t s3_in;
    tok_t s3_tok;
    tok_t s6_in;
    tok_t s6_tok;

    // stage 1: combine the two entry conditions
    assign s1_entry = '{vld: txn_vld_i, err: bad_input_i};

    err_stage_merge u_merge_s1 (
        .up   (s1_entry),
        .cond (illegal_op_i),
        .dn   (s1_tok)
    );

    // carry stage-1 flag to the overflow stage
    err_tok_delay #(.DEPTH(HOP_A)) u_hop_a (
        .clk (clk),
        .rst (rst),
        .d   (s1_tok),
        .q   (s3_in)
    );

    err_stage_merge u_merge_s3 (
        .up   (s3_in),
        .cond (overflow_i),
        .dn   (s3_tok)
    );

    // carry stage-3 flag to the divide stage
    err_tok_delay #(.DEPTH(HOP_B)) u_hop_b (
        .clk (clk),
        .rst (rst),
        .d   (s3_tok),
        .q   (s6_in)
    );

    err_stage_merge u_merge_s6 (
        .up   (s6_in),
        .cond (div_zero_i),
        .dn   (s6_tok)
    );

    assign txn_vld_o = s6_tok.vld;
    assign err_o     = s6_tok.err;

    // cycles since reset release, saturating, used only by checks
    logic [FCW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
        end else if (fill_cnt < FCW'(LAT)) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // R9: nothing emerges while the pipeline refills after reset
    assert_no_output_in_fill_R9: assert property (
        @(posedge clk) disable iff (rst)
        (fill_cnt < FCW'(LAT)) |-> (!txn_vld_o && !err_o)
    );

    // R6: error flag only with a valid output slot
    assert_err_needs_vld_R6: assert property (
        @(posedge clk) disable iff (rst)
        err_o |-> txn_vld_o
    );

    // R3: late divide condition always reaches the final flag
    assert_div_zero_flags_R3: assert property (
        @(posedge clk) disable iff (rst)
        (div_zero_i && txn_vld_o) |-> err_o
    );

    // R2: overflow at the middle stage is recorded for that transaction
    assert_overflow_recorded_R2: assert property (
        @(posedge clk) disable iff (rst)
        (overflow_i && s3_in.vld) |-> s3_tok.err
    );

endmodule

// File: tb/err_pipe_agg_tb_top.sv
module err_pipe_agg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 800;
    localparam int LAT        = 5;
    localparam int RST_AT     = 600;
    localparam int RST_LEN    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txn_vld_i = 1'b0, bad_input_i = 1'b0, illegal_op_i = 1'b0;
    logic overflow_i = 1'b0, div_zero_i = 1'b0;
    logic txn_vld_o, err_o;

    logic a_v   [NCYC];
    logic a_bad [NCYC];
    logic a_ill [NCYC];
    logic a_ovf [NCYC];
    logic a_div [NCYC];

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_pipe_agg dut_i (
        .clk          (clk),
        .rst          (rst),
        .txn_vld_i    (txn_vld_i),
        .bad_input_i  (bad_input_i),
        .illegal_op_i (illegal_op_i),
        .overflow_i   (overflow_i),
        .div_zero_i   (div_zero_i),
        .txn_vld_o    (txn_vld_o),
        .err_o        (err_o)
    );

    task automatic check(input string tag, input int cyc, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    function automatic logic at(input logic arr [NCYC], input int idx, input int lo);
        if (idx < lo || idx >= NCYC) return 1'b0;
        return arr[idx];
    endfunction

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NCYC; i++) begin
            a_v[i] = 0; a_bad[i] = 0; a_ill[i] = 0; a_ovf[i] = 0; a_div[i] = 0;
        end
        // sparse sweep: every combination of six stimulus bits, one transaction per 6 cycles
        for (int c = 0; c < 64; c++) begin
            int b;
            b = 6 * c;
            a_v[b]     = c[0];
            a_bad[b]   = c[1];
            a_ill[b]   = c[2];
            a_ovf[b+2] = c[3];
            a_div[b+5] = c[4];
            a_ovf[b+3] = c[5]; // R8: misaligned overflow, belongs to empty slot b+1
        end
        // dense pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 384; i < NCYC - 8; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a_v[i]   = lfsr[0] | lfsr[5];
            a_bad[i] = lfsr[1] & lfsr[7];
            a_ill[i] = lfsr[2] & lfsr[9];
            a_ovf[i] = lfsr[3] & lfsr[11];
            a_div[i] = lfsr[4] & lfsr[13];
        end
        for (int i = RST_AT; i < RST_AT + RST_LEN; i++) begin
            a_v[i] = 0; a_bad[i] = 0; a_ill[i] = 0; a_ovf[i] = 0; a_div[i] = 0;
        end
    end

    initial begin
        int rel;
        rel = 0;
        repeat (3) @(posedge clk);
        for (int n = 0; n < NCYC; n++) begin
            logic ev, ee;
            int t;
            @(negedge clk);
            rst          = (n >= RST_AT && n < RST_AT + RST_LEN);
            txn_vld_i    = a_v[n];
            bad_input_i  = a_bad[n];
            illegal_op_i = a_ill[n];
            overflow_i   = a_ovf[n];
            div_zero_i   = a_div[n];
            if (n == RST_AT + RST_LEN) rel = n;
            #1;
            if (!rst) begin
                t  = n - LAT;
                ev = at(a_v, t, rel);
                ee = ev & (at(a_bad, t, rel) | at(a_ill, t, rel)
                         | at(a_ovf, t + 2, rel) | a_div[n]);
                if (n - rel < LAT) begin
                    check("R9 fill vld", n, txn_vld_o, 1'b0);
                    check("R9 fill err", n, err_o, 1'b0);
                end else begin
                    check("R5 vld", n, txn_vld_o, ev);
                    if (!ev)
                        check("R7/R6 invalid slot err", n, err_o, 1'b0);
                    else if (at(a_bad, t, rel) | at(a_ill, t, rel))
                        check("R1 entry err", n, err_o, 1'b1);
                    else if (at(a_ovf, t + 2, rel))
                        check("R2 overflow err", n, err_o, 1'b1);
                    else if (a_div[n])
                        check("R3 divide err", n, err_o, 1'b1);
                    else
                        check("R4/R8 clean err", n, err_o, ee);
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule